// File: doc/BRIEF.md
# Short-Immediate Register Load Unit

This unit carries out the two 16-bit short-immediate instructions of a small 32-bit processor. It owns a 16-entry register file of 32-bit words. Each cycle it accepts one instruction halfword, qualified by a valid strobe.

The load form writes the destination with an 8-bit constant, sign-extended to the full word. The merge form shifts the destination's current value up by one byte and places the constant, without sign extension, in the low byte. A load followed by merges builds an arbitrary 32-bit constant. Neither form alters the condition flags.

A zero destination field is refused with an illegal-instruction signal. A halfword from any other instruction family is left alone and marked as not handled, so that another unit can claim it. A combinational read port and a flag output let the surrounding logic observe the state.

Top module: `simm_regload`

## Requirements
- R1: The halfword fields are: constant in bits 15:8, opcode in bits 7:4, destination register number in bits 3:0.
- R2: Opcode 4'b1101 (load) writes the destination with the constant sign-extended to 32 bits. Constant 8'h7F gives 32'h0000007F and 8'h80 gives 32'hFFFFFF80.
- R3: Opcode 4'b1100 (merge) writes the destination with {old[23:0], constant}.
- R4: The NZVC flag output (bit 3 N, bit 2 Z, bit 1 V, bit 0 C) keeps its value across every instruction. After reset it is 4'b0000.
- R5: A load or merge with destination 0 raises `illegal` in the same cycle. It writes no register, and register 0 keeps reading 0.
- R6: A load with constant 0 clears the destination to 32'h0.
- R7: A load of a constant's top byte followed by three merges of the remaining bytes leaves the full 32-bit constant in the register.
- R8: Writes take effect on the rising clock edge while `insn_valid` is high. A synchronous active-high `rst` clears every register and the flags.
- R9: A valid halfword whose opcode bits 7:5 are not 3'b110 raises `not_handled` in the same cycle and writes nothing.
- R10: `rd_data` shows register `rd_sel` combinationally, with no clock edge needed.
- R11: With `insn_valid` low, nothing is written and both `illegal` and `not_handled` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| insn_valid | input | 1 | Instruction halfword is present this cycle |
| insn | input | 16 | Instruction halfword |
| rd_sel | input | 4 | Register number for the read port |
| rd_data | output | 32 | Contents of register `rd_sel` |
| nzvc | output | 4 | Condition flags N, Z, V, C |
| illegal | output | 1 | Load or merge aimed at register 0 |
| not_handled | output | 1 | Valid halfword outside this instruction family |

## Verification
Several vectors target the sign boundary: 8'h7F against 8'h80. A design that extended the wrong bit, or zero-extended the constant, returns 32'h00000080 where 32'hFFFFFF80 is expected. Merges are chained onto a sign-extended load to build 32'hDEADBEEF. A merge that kept the old low byte, sign-extended the constant, or did not shift would corrupt the upper bytes.

A zero destination is tried with both opcodes, followed by a read of register 0 and of a live register. A design that wrote anyway shows a non-zero register 0. Foreign opcodes and halfwords presented with the strobe low are also applied, and the registers they could reach are read back afterwards. Any stray write shows up as a changed value.

// File: rtl/simm_regload.sv
module simm_regload #(
  parameter int XLEN  = 32,
  parameter int NREGS = 16,
  parameter int IMMW  = 8,
  parameter int INSNW = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     insn_valid,
  input  logic [INSNW-1:0]         insn,
  input  logic [$clog2(NREGS)-1:0] rd_sel,
  output logic [XLEN-1:0]          rd_data,
  output logic [3:0]               nzvc,
  output logic                     illegal,
  output logic                     not_handled
);
  localparam int AW  = $clog2(NREGS);
  localparam int LOW = INSNW - IMMW;
  localparam int OPW = LOW - AW;
  localparam logic [OPW-2:0] FAMILY = 3'b110;

  logic [XLEN-1:0] rf [NREGS];
  logic [3:0]      flags_q;

  logic [AW-1:0]   dst;
  logic [OPW-1:0]  opc;
  logic [IMMW-1:0] imm;
  logic            ours, we;
  logic [XLEN-1:0] cur, wdata;

  assign dst = insn[AW-1:0];
  assign opc = insn[LOW-1:AW];
  assign imm = insn[INSNW-1:LOW];

  assign ours        = opc[OPW-1:1] == FAMILY;
  assign illegal     = insn_valid && ours && (dst == '0);
  assign not_handled = insn_valid && !ours;
  assign we          = insn_valid && ours && (dst != '0);

  assign cur   = rf[dst];
  assign wdata = opc[0] ? {{(XLEN-IMMW){imm[IMMW-1]}}, imm}
                        : {cur[XLEN-IMMW-1:0], imm};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) rf[i] <= '0;
    end else if (we) begin
      rf[dst] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_q;
  end

  assign rd_data = rf[rd_sel];
  assign nzvc    = flags_q;

  logic [NREGS*XLEN-1:0] rf_flat;
  for (genvar g = 0; g < NREGS; g++) begin : g_flat
    assign rf_flat[g*XLEN +: XLEN] = rf[g];
  end

  assert_load_sext_R2: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && ours && opc[0] && dst != '0) |=>
      rf[$past(dst)] == {{(XLEN-IMMW){$past(imm[IMMW-1])}}, $past(imm)});

  assert_merge_shift_R3: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && ours && !opc[0] && dst != '0) |=>
      rf[$past(dst)] == {$past(cur[XLEN-IMMW-1:0]), $past(imm)});

  assert_zero_dst_R5: assert property (@(posedge clk) disable iff (rst)
    illegal |=> $stable(rf_flat) && rf[0] == '0);

  assert_foreign_R9: assert property (@(posedge clk) disable iff (rst)
    (not_handled || !insn_valid) |=> $stable(rf_flat));

  assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !insn_valid |-> !illegal && !not_handled);
endmodule

// File: tb/simm_regload_tb_top.sv
module simm_regload_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        insn_valid;
  logic [15:0] insn;
  logic [3:0]  rd_sel;
  logic [31:0] rd_data;
  logic [3:0]  nzvc;
  logic        illegal, not_handled;

  int checks = 0;
  int errors = 0;
  logic s_ill, s_nh;

  always #4 clk = ~clk;

  simm_regload dut_i (
    .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn(insn),
    .rd_sel(rd_sel), .rd_data(rd_data), .nzvc(nzvc),
    .illegal(illegal), .not_handled(not_handled)
  );

  // R1 layout: {constant[15:8], opcode[7:4], dst[3:0]}; entry = {insn, sel, expected}
  localparam int NV = 11;
  localparam logic [51:0] VEC [NV] = '{
    {16'h7FD1, 4'd1,  32'h0000007F},   // R2 positive edge
    {16'h80D2, 4'd2,  32'hFFFFFF80},   // R2 negative edge
    {16'h55D3, 4'd3,  32'h00000055},
    {16'h00D3, 4'd3,  32'h00000000},   // R6 clear
    {16'h12C2, 4'd2,  32'hFFFF8012},   // R3
    {16'hDED4, 4'd4,  32'hFFFFFFDE},   // R7 build
    {16'hADC4, 4'd4,  32'hFFFFDEAD},
    {16'hBEC4, 4'd4,  32'hFFDEADBE},
    {16'hEFC4, 4'd4,  32'hDEADBEEF},
    {16'h01C1, 4'd1,  32'h00007F01},   // R3
    {16'hFFDF, 4'd15, 32'hFFFFFFFF}    // R2
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rdchk(input string req, input logic [3:0] sel, input logic [31:0] exp);
    rd_sel = sel;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic issue(input logic [15:0] h, input logic v);
    @(negedge clk);
    insn = h;
    insn_valid = v;
    #1;
    s_ill = illegal;
    s_nh  = not_handled;
    @(negedge clk);
    insn_valid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; insn_valid = 1'b0; insn = '0; rd_sel = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R8 reset state
    for (int r = 0; r < 16; r++) rdchk("R8 reset reg", r[3:0], 32'h0);
    chk("R4 reset flags", {28'h0, nzvc}, 32'h0);
    chk("R11 idle illegal", {31'h0, illegal}, 32'h0);
    chk("R11 idle not_handled", {31'h0, not_handled}, 32'h0);

    // R2 R3 R6 R7 vector walk
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][51:36], 1'b1);
      rdchk("R2/R3/R6/R7 vector", VEC[i][35:32], VEC[i][31:0]);
      chk("R4 flags held", {28'h0, nzvc}, 32'h0);
    end

    // R10 combinational read: select changes, no clock edge
    @(negedge clk);
    rd_sel = 4'd4; #1; chk("R10 read r4", rd_data, 32'hDEADBEEF);
    rd_sel = 4'd2; #1; chk("R10 read r2", rd_data, 32'hFFFF8012);

    // R5 zero destination, both opcodes
    issue(16'h55D0, 1'b1);
    chk("R5 illegal load", {31'h0, s_ill}, 32'h1);
    rdchk("R5 r0 after load", 4'd0, 32'h0);
    issue(16'h77C0, 1'b1);
    chk("R5 illegal merge", {31'h0, s_ill}, 32'h1);
    chk("R5 merge not foreign", {31'h0, s_nh}, 32'h0);
    rdchk("R5 r0 after merge", 4'd0, 32'h0);
    rdchk("R5 r1 untouched", 4'd1, 32'h00007F01);

    // R9 foreign opcodes
    issue(16'h99E5, 1'b1);
    chk("R9 not_handled E", {31'h0, s_nh}, 32'h1);
    chk("R9 not illegal", {31'h0, s_ill}, 32'h0);
    rdchk("R9 r5 untouched", 4'd5, 32'h0);
    issue(16'h3341, 1'b1);
    chk("R9 not_handled 4", {31'h0, s_nh}, 32'h1);
    rdchk("R9 r1 untouched", 4'd1, 32'h00007F01);
    issue(16'h2250, 1'b1);
    chk("R9 foreign r0 not illegal", {31'h0, s_ill}, 32'h0);

    // R11 strobe low
    issue(16'h11D1, 1'b0);
    chk("R11 no illegal", {31'h0, s_ill}, 32'h0);
    chk("R11 no not_handled", {31'h0, s_nh}, 32'h0);
    rdchk("R11 r1 untouched", 4'd1, 32'h00007F01);
    issue(16'h11D0, 1'b0);
    chk("R11 zero dst strobe low", {31'h0, s_ill}, 32'h0);

    chk("R4 flags final", {28'h0, nzvc}, 32'h0);

    // R8 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rdchk("R8 rerst r4", 4'd4, 32'h0);
    rdchk("R8 rerst r15", 4'd15, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule